// File: doc/BRIEF.md
# Smart Card Deactivation Sequencer

This block powers down a smart card contact interface in a safe order. Two sources can start it. A card event, such as removal or a fault, starts the teardown at once. A firmware write of the all-zero voltage-select code first waits a programmable number of ETU ticks. After that wait, the block drops the card reset, stops the card clock, pulls the data line low and removes the supply, one step at a time.

The gap before each step comes from its own 8-bit reload value and is counted in system clock cycles. The clock is gated only while the card clock is low, so no shortened pulse reaches the card. When the supply switches off, the block raises a one-cycle done pulse and holds an inactive flag. After that it ignores every trigger until a re-activation strobe returns the interface to the powered state. The activation ramp itself is handled elsewhere.

Top module: `scard_deact_seq`

## Requirements
- R1: After reset the interface is inactive: rst_o=0, clk_o=0, io_low_o=1, vcc_en_o=0, inactive_o=1, done_o=0.
- R2: A card event sampled at edge k in the active state drives rst_o low at edge k+t1+1. A step value of v therefore lasts v+1 cycles, and 0 gives one cycle.
- R3: A firmware trigger is a vsel_wr_i strobe with vsel_i equal to 0. A write with any non-zero code has no effect.
- R4: For a firmware trigger at edge k with ETU delay N, the t1 interval starts at the edge that samples the N-th etu_tick_i after k. N=0 starts it at k. A card event needs no ETU tick.
- R5: A card event sampled during the ETU wait ends the wait. The t1 interval starts at that edge.
- R6: While running, clk_o at each edge equals card_clk_i sampled at that edge. The stop becomes due t2+1 cycles after rst_o falls. It takes effect at the first edge from then on that samples card_clk_i low, and clk_o stays 0 afterwards.
- R7: io_low_o rises t3+1 cycles after the clock-stop edge.
- R8: vcc_en_o falls t4+1 cycles after io_low_o rises. done_o pulses high for exactly that one cycle, and inactive_o rises with it.
- R9: Triggers are ignored during the teardown and while inactive. A reactivate_i strobe in the inactive state restores rst_o=1, vcc_en_o=1, io_low_o=0 and a running clock, and clears inactive_o.
- R10: A card event and a firmware trigger in the same cycle take the card-event path, with no ETU wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_evt_i | input | 1 | Card event trigger (removal or fault) |
| vsel_wr_i | input | 1 | Firmware voltage-select write strobe |
| vsel_i | input | VSEL_W | Voltage-select code written; 0 requests power-down |
| etu_tick_i | input | 1 | One-cycle pulse per ETU |
| etu_dly_i | input | ETU_W | ETU delay before a firmware teardown |
| t1_i | input | STEP_W | Trigger to reset-low interval, reload value |
| t2_i | input | STEP_W | Reset-low to clock-stop interval |
| t3_i | input | STEP_W | Clock-stop to IO-low interval |
| t4_i | input | STEP_W | IO-low to supply-off interval |
| card_clk_i | input | 1 | Card clock level, synchronous to clk_i |
| reactivate_i | input | 1 | Return to the powered state when inactive |
| rst_o | output | 1 | Card reset line (0 = reset asserted) |
| clk_o | output | 1 | Gated card clock |
| io_low_o | output | 1 | Pull the IO line low |
| vcc_en_o | output | 1 | Card supply enable |
| done_o | output | 1 | One-cycle pulse when the supply turns off |
| inactive_o | output | 1 | Interface is powered down |

## Verification
The bench uses different card clock half-periods, so the stop request lands in both the high and the low phase. A design that gated on the high phase would chop a pulse, and one that waited an extra phase would shift the IO and supply edges by a predictable number of cycles. Card events are sent before, during and after the last ETU tick, and together with a firmware write. A design that let the ETU wait run on would drop the reset late, and one that favoured firmware would add the ETU delay. Step values of 0 and 255 expose off-by-one reload counting. Extra triggers during the teardown, and while inactive, would restart or corrupt the sequence or produce a second done pulse if they were not ignored.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_ON, ST_ETU, ST_T1, ST_T2, ST_T3, ST_T4
  } sd_state_e;
endpackage

// File: rtl/sd_step_timer.sv
module sd_step_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/sd_etu_wait.sv
module sd_etu_wait #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = tick_i && (cnt_q == ONE);

  AST_ETU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/sd_clk_gate.sv
module sd_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_clk_i,
  input  logic start_i,
  input  logic stop_req_i,
  output logic clk_o,
  output logic run_o,
  output logic stop_ack_o
);
  logic run_q;

  // stop is taken only while the card clock is low
  assign stop_ack_o = stop_req_i && run_q && !card_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      clk_o <= card_clk_i && run_q;
      if (start_i)         run_q <= 1'b1;
      else if (stop_ack_o) run_q <= 1'b0;
    end
  end

  assign run_o = run_q;

  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !$past(card_clk_i)); // R6
endmodule

// File: rtl/scard_deact_seq.sv
module scard_deact_seq
  import sd_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int ETU_W  = 8,
  parameter int VSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_evt_i,
  input  logic              vsel_wr_i,
  input  logic [VSEL_W-1:0] vsel_i,
  input  logic              etu_tick_i,
  input  logic [ETU_W-1:0]  etu_dly_i,
  input  logic [STEP_W-1:0] t1_i,
  input  logic [STEP_W-1:0] t2_i,
  input  logic [STEP_W-1:0] t3_i,
  input  logic [STEP_W-1:0] t4_i,
  input  logic              card_clk_i,
  input  logic              reactivate_i,
  output logic              rst_o,
  output logic              clk_o,
  output logic              io_low_o,
  output logic              vcc_en_o,
  output logic              done_o,
  output logic              inactive_o
);
  sd_state_e state_q, state_d;
  logic [STEP_W-1:0] tmr_val;
  logic tmr_load, tmr_zero, etu_load, etu_last;
  logic stop_req, stop_ack, clk_run, go_on, rst_fall, io_set, vcc_clr;
  logic rst_q, io_q, vcc_q, done_q;
  logic fw_req;

  assign fw_req = vsel_wr_i && (vsel_i == '0);

  sd_step_timer #(.W(STEP_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  sd_etu_wait #(.W(ETU_W)) u_etu (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(etu_load), .val_i(etu_dly_i),
    .tick_i(etu_tick_i), .last_o(etu_last)
  );

  sd_clk_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .card_clk_i(card_clk_i), .start_i(go_on),
    .stop_req_i(stop_req), .clk_o(clk_o), .run_o(clk_run), .stop_ack_o(stop_ack)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = t1_i;
    etu_load = 1'b0;
    stop_req = 1'b0;
    go_on    = 1'b0;
    rst_fall = 1'b0;
    io_set   = 1'b0;
    vcc_clr  = 1'b0;
    unique case (state_q)
      ST_OFF: if (reactivate_i) begin
        state_d = ST_ON;
        go_on   = 1'b1;
      end
      ST_ON: begin
        if (card_evt_i || (fw_req && etu_dly_i == '0)) begin
          state_d  = ST_T1;
          tmr_load = 1'b1;
        end else if (fw_req) begin
          state_d  = ST_ETU;
          etu_load = 1'b1;
        end
      end
      ST_ETU: if (card_evt_i || etu_last) begin
        state_d  = ST_T1;
        tmr_load = 1'b1;
      end
      ST_T1: if (tmr_zero) begin
        state_d  = ST_T2;
        tmr_load = 1'b1;
        tmr_val  = t2_i;
        rst_fall = 1'b1;
      end
      ST_T2: begin
        stop_req = tmr_zero;
        if (stop_ack) begin
          state_d  = ST_T3;
          tmr_load = 1'b1;
          tmr_val  = t3_i;
        end
      end
      ST_T3: if (tmr_zero) begin
        state_d  = ST_T4;
        tmr_load = 1'b1;
        tmr_val  = t4_i;
        io_set   = 1'b1;
      end
      ST_T4: if (tmr_zero) begin
        state_d = ST_OFF;
        vcc_clr = 1'b1;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rst_q   <= 1'b0;
      io_q    <= 1'b1;
      vcc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= vcc_clr;
      if (go_on)         rst_q <= 1'b1;
      else if (rst_fall) rst_q <= 1'b0;
      if (go_on)         io_q  <= 1'b0;
      else if (io_set)   io_q  <= 1'b1;
      if (go_on)         vcc_q <= 1'b1;
      else if (vcc_clr)  vcc_q <= 1'b0;
    end
  end

  assign rst_o      = rst_q;
  assign io_low_o   = io_q;
  assign vcc_en_o   = vcc_q;
  assign done_o     = done_q;
  assign inactive_o = (state_q == ST_OFF);

  AST_CLK_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_run |-> !rst_q); // R6
  AST_IO_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_q |-> !clk_run); // R7
  AST_VCC_AFTER_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_q |-> io_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_INACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> inactive_o); // R8
endmodule

// File: tb/sim_scard_deact_seq.sv
module sim_scard_deact_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic card_evt = 0, vsel_wr = 0, etu_tick = 0, card_clk = 0, react = 0;
  logic [1:0] vsel = 2'd3;
  logic [7:0] etu_dly = 0, t1 = 0, t2 = 0, t3 = 0, t4 = 0;
  logic rst_o, clk_o, io_low, vcc_en, done, inact;
  int cyc = 0, checks = 0, errors = 0, hp = 2, ep = 3;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scard_deact_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .card_evt_i(card_evt), .vsel_wr_i(vsel_wr), .vsel_i(vsel),
    .etu_tick_i(etu_tick), .etu_dly_i(etu_dly), .t1_i(t1), .t2_i(t2), .t3_i(t3), .t4_i(t4),
    .card_clk_i(card_clk), .reactivate_i(react), .rst_o(rst_o), .clk_o(clk_o),
    .io_low_o(io_low), .vcc_en_o(vcc_en), .done_o(done), .inactive_o(inact)
  );

  function automatic bit ccv(int c); return ((c / hp) % 2) == 1; endfunction
  function automatic bit tk(int c);  return (c % ep) == 0;       endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    card_clk <= ccv(cyc + 1);
    etu_tick <= tk(cyc + 1);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reactivate();
    @(negedge clk); react = 1;
    @(negedge clk); react = 0;
    repeat (3) @(negedge clk);
    chk("R9 reactivated rst_o", rst_o, 1);
    chk("R9 reactivated vcc_en_o", vcc_en, 1);
    chk("R9 reactivated io_low_o", io_low, 0);
    chk("R9 reactivated inactive_o", inact, 0);
  endtask

  // mode 0 card event, 1 firmware, 2 firmware + card cancel, 3 both at once
  task automatic run_seq(input int mode, input int a1, input int a2, input int a3,
                         input int a4, input int n, input int ca, input bit extra);
    int k, e, r, s, io_e, v, kc, cnt;
    int o_r, o_io, o_v, o_d, d_cnt, clk_bad;
    t1 = 8'(a1); t2 = 8'(a2); t3 = 8'(a3); t4 = 8'(a4); etu_dly = 8'(n);
    @(negedge clk);
    if (mode == 0 || mode == 3) card_evt = 1;
    if (mode != 0) begin vsel_wr = 1; vsel = 2'd0; end
    k = cyc + 1;
    e = k;
    if ((mode == 1 || mode == 2) && n > 0) begin
      cnt = 0;
      for (int c = k + 1; cnt < n; c++) if (tk(c)) begin cnt++; e = c; end
    end
    kc = k + ca;
    if (mode == 2 && kc < e) e = kc;
    r = e + a1 + 1;
    s = r + a2 + 1;
    while (ccv(s)) s++;
    io_e = s + a3 + 1;
    v = io_e + a4 + 1;
    o_r = -1; o_io = -1; o_v = -1; o_d = -1; d_cnt = 0; clk_bad = 0;
    @(negedge clk);
    card_evt = 0; vsel_wr = 0; vsel = 2'd3;
    while (cyc <= v + 2) begin
      if (o_r < 0 && !rst_o) o_r = cyc;
      if (o_io < 0 && io_low) o_io = cyc;
      if (o_v < 0 && !vcc_en) o_v = cyc;
      if (done) begin d_cnt++; if (o_d < 0) o_d = cyc; end
      if (clk_o != ((cyc < s) ? ccv(cyc) : 1'b0)) clk_bad++;
      card_evt = (mode == 2 && cyc == kc - 1) || (extra && (cyc == r || cyc == v + 1));
      vsel_wr  = extra && (cyc == r + 1 || cyc == v + 1);
      vsel     = vsel_wr ? 2'd0 : 2'd3;
      @(negedge clk);
    end
    card_evt = 0; vsel_wr = 0; vsel = 2'd3;
    case (mode)
      0: chk("R2 rst_o fall cycle", o_r, r);
      1: chk("R4 rst_o fall cycle", o_r, r);
      2: chk("R5 rst_o fall cycle", o_r, r);
      default: chk("R10 rst_o fall cycle", o_r, r);
    endcase
    chk("R6 clk_o tracking mismatches", clk_bad, 0);
    chk("R7 io_low_o rise cycle", o_io, io_e);
    chk("R8 vcc_en_o fall cycle", o_v, v);
    chk("R8 done_o cycle", o_d, v);
    chk(extra ? "R9 done_o pulses with extra triggers" : "R8 done_o pulses", d_cnt, 1);
    chk("R8 inactive_o at end", inact, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed1209));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_o", rst_o, 0); chk("R1 clk_o", clk_o, 0); chk("R1 io_low_o", io_low, 1);
    chk("R1 vcc_en_o", vcc_en, 0); chk("R1 inactive_o", inact, 1); chk("R1 done_o", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    reactivate();
    // R3 non-zero code ignored
    @(negedge clk); vsel_wr = 1; vsel = 2'd2;
    @(negedge clk); vsel_wr = 0; vsel = 2'd3;
    repeat (30) @(negedge clk);
    chk("R3 rst_o after non-zero write", rst_o, 1);
    chk("R3 vcc_en_o after non-zero write", vcc_en, 1);
    chk("R3 inactive_o after non-zero write", inact, 0);
    // directed corners
    hp = 1; run_seq(0, 0, 0, 0, 0, 0, 0, 0); reactivate();
    hp = 3; run_seq(0, 255, 255, 255, 255, 0, 0, 0); reactivate();
    hp = 2; run_seq(1, 2, 1, 0, 3, 0, 0, 0); reactivate();
    ep = 4; run_seq(1, 1, 2, 3, 4, 3, 0, 0); reactivate();
    run_seq(2, 0, 1, 1, 1, 4, 2, 0); reactivate();
    run_seq(2, 0, 1, 1, 1, 2, 40, 1); reactivate();
    run_seq(3, 3, 3, 3, 3, 5, 0, 0);
    // R9 ignored while inactive
    @(negedge clk); card_evt = 1; vsel_wr = 1; vsel = 2'd0;
    @(negedge clk); card_evt = 0; vsel_wr = 0; vsel = 2'd3;
    begin
      int dn = 0;
      repeat (40) begin @(negedge clk); if (done) dn++; end
      chk("R9 done_o while inactive", dn, 0);
    end
    chk("R9 inactive_o held", inact, 1);
    chk("R9 vcc_en_o held off", vcc_en, 0);
    chk("R9 rst_o held low", rst_o, 0);
    reactivate();
    // random runs
    for (int i = 0; i < 40; i++) begin
      hp = 1 + int'($urandom_range(2));
      ep = 2 + int'($urandom_range(3));
      run_seq(int'($urandom_range(3)), int'($urandom_range(15)), int'($urandom_range(15)),
              int'($urandom_range(15)), int'($urandom_range(15)), int'($urandom_range(4)),
              1 + int'($urandom_range(12)), bit'($urandom_range(1)));
      reactivate();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule